// File: doc/BRIEF.md
# Parallel Port Enhanced Address/Data Cycle Engine

This block sits behind the host register window of a parallel port and adds the enhanced-mode address register (offset 3) and data register (offset 4) next to the data (offset 0), status (offset 1) and control (offset 2) registers. The host issues one access at a time with `req_i`. The block decides from the stored control byte whether an enhanced cycle may start. If it may, the block runs one strobe/wait handshake per byte with the peripheral. Otherwise the access is dropped without a bus cycle.

Accesses to the data register may be 8, 16 or 32 bits wide. They are split into byte transfers, least significant byte first. A byte the peripheral does not acknowledge within `wait_limit_i` clock cycles ends the access early and sets a sticky timeout flag. The flag is visible as status bit 0, and writing 1 to that bit clears it. Every accepted access ends with a one-cycle `done_o` pulse, and read data is valid only in that cycle.

Control writes always set bits 7:6. A write of a value already held in control or data is discarded without any pin activity. A change of the direction bit (control bit 5) is announced for one cycle before the new control byte is driven.

Top module: `epp_cycle_engine`

## Requirements
- R1: After reset, control reads 0xCC, data reads 0xFF, status reads `{status_i[7:1],0}` and `ready_o` is high.
- R2: A control write stores the written byte OR 0xC0. `ctl_wr_o` is high for one cycle, and `ctl_o` carries the new value from the end of that cycle.
- R3: A control or data write equal to the stored value produces no `ctl_wr_o` or `dat_wr_o` pulse, leaves `ctl_o` stable and completes one cycle after acceptance.
- R4: A control write that flips bit 5 raises `dir_chg_o` for one cycle, immediately followed by the `ctl_wr_o` cycle. `done_o` follows 2 cycles after acceptance instead of 1.
- R5: An enhanced write (offset 3 or 4) strobes the peripheral only when `ctl & 0x2F == 0x04`. Otherwise no strobe occurs and the timeout flag keeps its value.
- R6: An enhanced read strobes only when `ctl & 0x2F == 0x24`. A gated-off read returns all ones over the requested width (1, 2 or 4 bytes) and zeros above it.
- R7: Offset 4 transfers 1, 2 or 4 bytes for `size_i` 0, 1 or 2 (3 treated as 2), least significant byte first. Offset 3 always transfers one byte.
- R8: Each byte holds its strobe (`addr_stb_o` for offset 3, `data_stb_o` for offset 4) until `wait_i` is high, then takes one release cycle. An N-byte access with immediate acknowledge finishes 2N cycles after acceptance.
- R9: If `wait_i` stays low for `max(wait_limit_i,1)` strobe cycles, the byte fails, the timeout flag sets, and the remaining bytes are skipped. Read bytes not received return 0xFF.
- R10: Status reads return `{status_i[7:1], flag}`. A status write with bit 0 set clears the flag, and one with bit 0 clear leaves it.
- R11: `ready_o` is low from acceptance until `done_o`. `done_o` is a one-cycle pulse, and `rdata_o` is valid with it.
- R12: A data register read returns `pd_i` when control bit 5 is set, and otherwise returns the stored data byte. `pd_o` carries the stored byte outside write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, taken when `ready_o` is high |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register offset |
| size_i | input | 2 | Access width: 0 byte, 1 half, 2/3 word |
| wdata_i | input | 32 | Write data |
| ready_o | output | 1 | Idle, a request may be taken |
| done_o | output | 1 | Access complete pulse |
| rdata_o | output | 32 | Read data, valid with `done_o` |
| wait_limit_i | input | 8 | Handshake time-out in clock cycles |
| pd_i | input | 8 | Peripheral data in |
| pd_o | output | 8 | Peripheral data out |
| pd_oe_o | output | 1 | Data output enable (control bit 5 clear) |
| status_i | input | 8 | Peripheral status pins |
| wait_i | input | 1 | Peripheral acknowledge |
| addr_stb_o | output | 1 | Address byte strobe |
| data_stb_o | output | 1 | Data byte strobe |
| xfer_wr_o | output | 1 | Enhanced write cycle in progress |
| ctl_o | output | 8 | Driven control byte |
| ctl_wr_o | output | 1 | New control byte being driven |
| dir_chg_o | output | 1 | Direction change notice |
| dat_wr_o | output | 1 | New data byte being driven |

## Verification
Every result has a fixed latency counted from the acceptance edge:
- Register accesses complete after 1 cycle, or 2 when the direction flips.
- An acknowledged N-byte transfer completes after 2N cycles.
- A transfer that fails after k good bytes completes after 2k plus the limit.

The access task samples at falling edges and counts cycles from acceptance to `done_o`. It compares that count with the computed figure, and it records the cycle in which `dir_chg_o` and `ctl_wr_o` appear. A peripheral model in the bench acknowledges a chosen number of bytes and logs `pd_o`. Expected byte order and read words are derived from its acknowledge counter. The gating check is swept over all 64 settings of control bits 5:0, for both directions.

// File: rtl/epp_pkg.sv
package epp_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_REG, ST_DIR, ST_CTL, ST_XFER} eng_st_e;
  typedef enum logic [1:0] {HS_IDLE, HS_STB, HS_REL} hs_st_e;

  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd1;
  localparam logic [2:0] OFS_CTL  = 3'd2;
  localparam logic [2:0] OFS_EADR = 3'd3;
  localparam logic [2:0] OFS_EDAT = 3'd4;

  localparam logic [7:0] GATE_MASK = 8'h2F;
  localparam logic [7:0] GATE_WR   = 8'h04;
  localparam logic [7:0] GATE_RD   = 8'h24;
  localparam logic [7:0] CTL_SET   = 8'hC0;
  localparam logic [7:0] CTL_RST   = 8'hCC;
  localparam logic [7:0] DAT_RST   = 8'hFF;
  localparam int unsigned DIR_BIT  = 5;
endpackage

// File: rtl/epp_byte_hs.sv
module epp_byte_hs
  import epp_pkg::*;
#(
  parameter int unsigned LIM_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic             wait_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic             stb_o,
  output logic             ok_o,
  output logic             tmo_o,
  output logic             rel_o
);
  hs_st_e           ph_q;
  logic [LIM_W-1:0] cnt_q;
  logic [LIM_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign stb_o   = (ph_q == HS_STB);
  assign rel_o   = (ph_q == HS_REL);
  assign ok_o    = stb_o && wait_i;
  // limit 0 behaves as 1
  assign tmo_o   = stb_o && !wait_i && (cnt_inc >= {1'b0, limit_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= HS_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (ph_q)
        HS_IDLE: if (go_i) begin
          ph_q  <= HS_STB;
          cnt_q <= '0;
        end
        HS_STB: begin
          if (ok_o)       ph_q <= HS_REL;
          else if (tmo_o) ph_q <= HS_IDLE;
          else            cnt_q <= cnt_q + 1'b1;
        end
        HS_REL: begin
          cnt_q <= '0;
          ph_q  <= go_i ? HS_STB : HS_IDLE;
        end
        default: ph_q <= HS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/epp_lane_buf.sv
module epp_lane_buf #(
  parameter int unsigned BYTES = 4,
  localparam int unsigned IW   = $clog2(BYTES),
  localparam int unsigned DW   = 8 * BYTES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] load_val_i,
  input  logic          cap_i,
  input  logic [IW-1:0] idx_i,
  input  logic [7:0]    cap_byte_i,
  output logic [DW-1:0] word_o,
  output logic [7:0]    byte_o
);
  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                lane_q <= 8'hFF;
      else if (load_i)                            lane_q <= load_val_i[8*g +: 8];
      else if (cap_i && (idx_i == IW'(g)))        lane_q <= cap_byte_i;
    end
    assign word_o[8*g +: 8] = lane_q;
  end

  assign byte_o = word_o[8*idx_i +: 8];
endmodule

// File: rtl/epp_cycle_engine.sv
module epp_cycle_engine
  import epp_pkg::*;
#(
  parameter int unsigned BYTES = 4,
  parameter int unsigned LIM_W = 8,
  localparam int unsigned DW   = 8 * BYTES,
  localparam int unsigned IW   = $clog2(BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [1:0]       size_i,
  input  logic [DW-1:0]    wdata_i,
  output logic             ready_o,
  output logic             done_o,
  output logic [DW-1:0]    rdata_o,
  input  logic [LIM_W-1:0] wait_limit_i,
  input  logic [7:0]       pd_i,
  output logic [7:0]       pd_o,
  output logic             pd_oe_o,
  input  logic [7:0]       status_i,
  input  logic             wait_i,
  output logic             addr_stb_o,
  output logic             data_stb_o,
  output logic             xfer_wr_o,
  output logic [7:0]       ctl_o,
  output logic             ctl_wr_o,
  output logic             dir_chg_o,
  output logic             dat_wr_o
);
  function automatic logic [DW-1:0] lane_mask(logic [IW:0] n);
    logic [DW-1:0] m;
    m = '0;
    for (int i = 0; i < BYTES; i++) if (i < int'(n)) m[8*i +: 8] = 8'hFF;
    return m;
  endfunction

  eng_st_e       st_q;
  logic [7:0]    ctl_q, ctl_pend_q, dat_q;
  logic          tmo_q, done_q, dat_wr_q;
  logic [DW-1:0] rdata_q;
  logic          is_addr_q, is_wr_q;
  logic [IW-1:0] idx_q, last_q;
  logic [IW:0]   nb_q;

  logic          accept, is_enh, gate_ok, start_xfer;
  logic [IW:0]   nb_req;
  logic [7:0]    ctl_new;
  logic          hs_go, hs_stb, hs_ok, hs_tmo, hs_rel, more;
  logic [DW-1:0] lane_word;
  logic [7:0]    lane_byte;

  assign ready_o  = (st_q == ST_IDLE);
  assign accept   = req_i && ready_o;
  assign is_enh   = (addr_i == OFS_EADR) || (addr_i == OFS_EDAT);
  assign gate_ok  = we_i ? ((ctl_q & GATE_MASK) == GATE_WR)
                         : ((ctl_q & GATE_MASK) == GATE_RD);
  assign start_xfer = accept && is_enh && gate_ok;
  assign ctl_new  = wdata_i[7:0] | CTL_SET;

  always_comb begin
    if (addr_i != OFS_EDAT) nb_req = (IW+1)'(1);
    else begin
      unique case (size_i)
        2'd0:    nb_req = (IW+1)'(1);
        2'd1:    nb_req = (IW+1)'(2);
        default: nb_req = (IW+1)'(4);
      endcase
      if (nb_req > (IW+1)'(BYTES)) nb_req = (IW+1)'(BYTES);
    end
  end

  assign more  = (st_q == ST_XFER) && hs_rel && (idx_q != last_q);
  assign hs_go = start_xfer || more;

  epp_byte_hs #(.LIM_W(LIM_W)) u_hs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (hs_go),
    .wait_i  (wait_i),
    .limit_i (wait_limit_i),
    .stb_o   (hs_stb),
    .ok_o    (hs_ok),
    .tmo_o   (hs_tmo),
    .rel_o   (hs_rel)
  );

  epp_lane_buf #(.BYTES(BYTES)) u_lane (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start_xfer),
    .load_val_i (we_i ? wdata_i : '1),
    .cap_i      (hs_ok && !is_wr_q),
    .idx_i      (idx_q),
    .cap_byte_i (pd_i),
    .word_o     (lane_word),
    .byte_o     (lane_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      ctl_q      <= CTL_RST;
      ctl_pend_q <= CTL_RST;
      dat_q      <= DAT_RST;
      tmo_q      <= 1'b0;
      done_q     <= 1'b0;
      dat_wr_q   <= 1'b0;
      rdata_q    <= '0;
      is_addr_q  <= 1'b0;
      is_wr_q    <= 1'b0;
      idx_q      <= '0;
      last_q     <= '0;
      nb_q       <= '0;
    end else begin
      done_q   <= 1'b0;
      dat_wr_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          rdata_q <= '0;
          st_q    <= ST_REG;
          unique case (addr_i)
            OFS_DATA: begin
              if (we_i) begin
                if (wdata_i[7:0] != dat_q) begin
                  dat_q    <= wdata_i[7:0];
                  dat_wr_q <= 1'b1;
                end
              end else begin
                rdata_q <= DW'(ctl_q[DIR_BIT] ? pd_i : dat_q);
              end
            end
            OFS_STAT: begin
              if (we_i) begin
                if (wdata_i[0]) tmo_q <= 1'b0;
              end else begin
                rdata_q <= DW'({status_i[7:1], tmo_q});
              end
            end
            OFS_CTL: begin
              if (we_i) begin
                if (ctl_new != ctl_q) begin
                  ctl_pend_q <= ctl_new;
                  st_q <= (ctl_new[DIR_BIT] != ctl_q[DIR_BIT]) ? ST_DIR : ST_CTL;
                end
              end else begin
                rdata_q <= DW'(ctl_q);
              end
            end
            OFS_EADR, OFS_EDAT: begin
              if (gate_ok) begin
                st_q      <= ST_XFER;
                is_addr_q <= (addr_i == OFS_EADR);
                is_wr_q   <= we_i;
                idx_q     <= '0;
                last_q    <= IW'(nb_req - 1'b1);
                nb_q      <= nb_req;
              end else if (!we_i) begin
                rdata_q <= lane_mask(nb_req);
              end
            end
            default: if (!we_i) rdata_q <= DW'(8'hFF);
          endcase
        end
        ST_REG: begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
        end
        ST_DIR: st_q <= ST_CTL;
        ST_CTL: begin
          ctl_q  <= ctl_pend_q;
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
        end
        ST_XFER: begin
          if (hs_tmo) begin
            tmo_q   <= 1'b1;
            st_q    <= ST_IDLE;
            done_q  <= 1'b1;
            rdata_q <= is_wr_q ? '0 : (lane_word & lane_mask(nb_q));
          end else if (hs_rel) begin
            if (idx_q == last_q) begin
              st_q    <= ST_IDLE;
              done_q  <= 1'b1;
              rdata_q <= is_wr_q ? '0 : (lane_word & lane_mask(nb_q));
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o     = done_q;
  assign rdata_o    = rdata_q;
  assign ctl_o      = ctl_q;
  assign ctl_wr_o   = (st_q == ST_CTL);
  assign dir_chg_o  = (st_q == ST_DIR);
  assign dat_wr_o   = dat_wr_q;
  assign xfer_wr_o  = (st_q == ST_XFER) && is_wr_q;
  assign addr_stb_o = hs_stb && is_addr_q;
  assign data_stb_o = hs_stb && !is_addr_q;
  assign pd_o       = xfer_wr_o ? lane_byte : dat_q;
  assign pd_oe_o    = !ctl_q[DIR_BIT];
endmodule

// File: rtl/epp_cycle_engine_chk.sv
module epp_cycle_engine_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ready_o,
  input logic       done_o,
  input logic       addr_stb_o,
  input logic       data_stb_o,
  input logic       xfer_wr_o,
  input logic [7:0] ctl_o,
  input logic       ctl_wr_o,
  input logic       dir_chg_o,
  input logic       wait_i,
  input logic       tmo_flag
);
  logic stb;
  assign stb = addr_stb_o || data_stb_o;

  assert_wr_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb && xfer_wr_o) |-> ((ctl_o & 8'h2F) == 8'h04));
  assert_rd_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb && !xfer_wr_o) |-> ((ctl_o & 8'h2F) == 8'h24));
  assert_fixed_bits_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_o[7:6] == 2'b11);
  assert_no_silent_ctl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_wr_o |=> $stable(ctl_o));
  assert_dir_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_chg_o |=> ctl_wr_o);
  assert_one_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(addr_stb_o && data_stb_o));
  assert_tmo_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tmo_flag) |-> ($past(stb) && !$past(wait_i)));
  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !stb);
  assert_done_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_o);
  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind epp_cycle_engine epp_cycle_engine_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ready_o    (ready_o),
  .done_o     (done_o),
  .addr_stb_o (addr_stb_o),
  .data_stb_o (data_stb_o),
  .xfer_wr_o  (xfer_wr_o),
  .ctl_o      (ctl_o),
  .ctl_wr_o   (ctl_wr_o),
  .dir_chg_o  (dir_chg_o),
  .wait_i     (wait_i),
  .tmo_flag   (tmo_q)
);

// File: tb/sim_epp_cycle_engine.sv
`timescale 1ns/1ps
module sim_epp_cycle_engine;
  logic        clk = 0, rst_n = 0;
  logic        req = 0, we = 0;
  logic [2:0]  addr = 0;
  logic [1:0]  size = 0;
  logic [31:0] wdata = 0;
  logic        ready, done;
  logic [31:0] rdata;
  logic [7:0]  limit = 8'd3;
  logic [7:0]  pd_in, pd_out, status = 8'hB6;
  logic        pd_oe, wait_w, astb, dstb, xwr, ctl_wr, dir_chg, dat_wr;
  logic [7:0]  ctl;

  int checks = 0, errors = 0;
  int ack_cnt = 0, ack_base = 0, ack_lim = 1000000, stb_cnt = 0;
  logic resp_en = 1;
  logic [7:0] wlog [256];
  int lat, dir_at, cw_at, dw_cnt; logic rdy_bad, hung; logic [31:0] rd;

  always #4 clk = ~clk;

  epp_cycle_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .size_i(size),
    .wdata_i(wdata), .ready_o(ready), .done_o(done), .rdata_o(rdata),
    .wait_limit_i(limit), .pd_i(pd_in), .pd_o(pd_out), .pd_oe_o(pd_oe),
    .status_i(status), .wait_i(wait_w), .addr_stb_o(astb), .data_stb_o(dstb),
    .xfer_wr_o(xwr), .ctl_o(ctl), .ctl_wr_o(ctl_wr), .dir_chg_o(dir_chg), .dat_wr_o(dat_wr));

  // peripheral model: acknowledges while budget lasts
  assign wait_w = resp_en && (astb || dstb) && ((ack_cnt - ack_base) < ack_lim);
  assign pd_in  = 8'(ack_cnt) + 8'h30;
  always @(posedge clk) begin
    if (astb || dstb) stb_cnt <= stb_cnt + 1;
    if ((astb || dstb) && wait_w) begin
      wlog[ack_cnt % 256] <= pd_out;
      ack_cnt <= ack_cnt + 1;
    end
  end

  task automatic chk(input string req_s, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req_s, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [2:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = w; addr = a; size = s; wdata = d;
    @(negedge clk);
    req = 0;
    dir_at = 0; cw_at = 0; dw_cnt = 0; rdy_bad = 0; hung = 1; lat = -1; rd = '0;
    for (int i = 1; i < 2000; i++) begin
      if (dir_chg && dir_at == 0) dir_at = i;
      if (ctl_wr && cw_at == 0) cw_at = i;
      if (dat_wr) dw_cnt++;
      if (done) begin lat = i - 1; rd = rdata; hung = 0; break; end
      if (ready) rdy_bad = 1;
      @(negedge clk);
    end
    if (hung) begin
      errors++; checks++;
      $display("FAIL R11: access never completed, actual hung expected done");
    end
    @(negedge clk);
    chk("R11 done single pulse", 32'(done), 32'd0);
  endtask

  function automatic logic [31:0] ones(input int n);
    logic [31:0] m = '0;
    for (int i = 0; i < n; i++) m[8*i +: 8] = 8'hFF;
    return m;
  endfunction

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", 32'(ready), 32'd1);
    acc(0, 3'd2, 0, 0); chk("R1 ctl reset", rd, 32'hCC); chk("R11 reg latency", lat, 1);
    chk("R11 busy until done", 32'(rdy_bad), 0);
    acc(0, 3'd0, 0, 0); chk("R1 data reset", rd, 32'hFF);
    acc(0, 3'd1, 0, 0); chk("R1 status reset", rd, 32'hB6);

    // R2 control write
    acc(1, 3'd2, 0, 32'h04); chk("R2 latency", lat, 1); chk("R2 ctl_wr cycle", cw_at, 1);
    chk("R2 ctl_o", 32'(ctl), 32'hC4);
    acc(0, 3'd2, 0, 0); chk("R2 ctl read", rd, 32'hC4);
    // R3 redundant writes
    acc(1, 3'd2, 0, 32'hC4); chk("R3 ctl no pulse", cw_at, 0); chk("R3 latency", lat, 1);
    acc(1, 3'd0, 0, 32'h3C); chk("R3 first data pulse", dw_cnt, 1);
    chk("R12 pd_o holds data", 32'(pd_out), 32'h3C); chk("R12 pd_oe", 32'(pd_oe), 1);
    acc(1, 3'd0, 0, 32'h3C); chk("R3 data no pulse", dw_cnt, 0);
    acc(0, 3'd0, 0, 0); chk("R12 data read dir0", rd, 32'h3C);
    // R4 direction change
    acc(1, 3'd2, 0, 32'h24); chk("R4 dir notice cycle", dir_at, 1); chk("R4 ctl_wr after", cw_at, 2);
    chk("R4 latency", lat, 2); chk("R4 ctl_o", 32'(ctl), 32'hE4);
    acc(0, 3'd0, 0, 0); chk("R12 data read dir1", rd, 32'(8'(ack_cnt) + 8'h30));

    // R5/R6 gate sweep over control bits 5:0
    for (int c = 0; c < 64; c++) begin
      int s0;
      acc(1, 3'd2, 0, 32'(c));
      s0 = stb_cnt;
      acc(1, 3'd4, 0, 32'h11);
      chk("R5 write gate", stb_cnt - s0, ((c & 8'h2F) == 8'h04) ? 1 : 0);
      s0 = stb_cnt;
      acc(0, 3'd3, 0, 0);
      chk("R6 read gate", stb_cnt - s0, ((c & 8'h2F) == 8'h24) ? 1 : 0);
      if ((c & 8'h2F) != 8'h24) chk("R6 gated byte ones", rd, 32'hFF);
    end
    acc(1, 3'd2, 0, 32'h00);
    acc(0, 3'd4, 1, 0); chk("R6 gated half ones", rd, 32'h0000FFFF);
    acc(0, 3'd4, 2, 0); chk("R6 gated word ones", rd, 32'hFFFFFFFF);
    acc(0, 3'd1, 0, 0); chk("R5 flag untouched", rd, 32'hB6);

    // R7/R8 wide writes
    acc(1, 3'd2, 0, 32'h04);
    for (int s = 0; s < 4; s++) begin
      for (int o = 3; o <= 4; o++) begin
        int n, b0; logic [31:0] d;
        d = 32'h44332211 + 32'(s * 16 + o);
        n = (o == 3) ? 1 : (s == 0 ? 1 : (s == 1 ? 2 : 4));
        b0 = ack_cnt;
        acc(1, 3'(o), 2'(s), d);
        chk("R8 write latency", lat, 2 * n);
        chk("R7 write byte count", ack_cnt - b0, n);
        for (int j = 0; j < n; j++) chk("R7 little-endian write", 32'(wlog[(b0 + j) % 256]), 32'(d[8*j +: 8]));
      end
    end
    // R7/R8 wide reads
    acc(1, 3'd2, 0, 32'h24);
    for (int s = 0; s < 3; s++) begin
      int n, b0; logic [31:0] e;
      n = (s == 0) ? 1 : (s == 1 ? 2 : 4);
      b0 = ack_cnt; e = '0;
      for (int j = 0; j < n; j++) e[8*j +: 8] = 8'(b0 + j) + 8'h30;
      acc(0, 3'd4, 2'(s), 0);
      chk("R8 read latency", lat, 2 * n);
      chk("R7 little-endian read", rd, e);
    end

    // R9 timeouts
    acc(1, 3'd2, 0, 32'h04);
    resp_en = 0;
    for (int l = 0; l < 5; l++) begin
      int s0; limit = 8'(l); s0 = ack_cnt;
      acc(1, 3'd4, 2, 32'hCAFEF00D);
      chk("R9 timeout latency", lat, (l == 0) ? 1 : l);
      chk("R9 no bytes", ack_cnt - s0, 0);
      acc(0, 3'd1, 0, 0); chk("R9 flag set", rd, 32'hB7);
      acc(1, 3'd1, 0, 32'h00);
      acc(0, 3'd1, 0, 0); chk("R10 write 0 keeps flag", rd, 32'hB7);
      acc(1, 3'd1, 0, 32'h01);
      acc(0, 3'd1, 0, 0); chk("R10 write 1 clears", rd, 32'hB6);
    end
    resp_en = 1; limit = 8'd3;
    ack_base = ack_cnt; ack_lim = 1;
    acc(1, 3'd4, 2, 32'h55667788);
    chk("R9 abort latency", lat, 2 + 3); chk("R9 bytes before abort", ack_cnt - ack_base, 1);
    // gated-off write leaves set flag
    acc(1, 3'd2, 0, 32'h00);
    begin
      int s0; s0 = stb_cnt;
      acc(1, 3'd3, 0, 32'h99); chk("R5 gated no strobe", stb_cnt - s0, 0);
    end
    acc(0, 3'd1, 0, 0); chk("R5 gated keeps flag", rd, 32'hB7);
    acc(1, 3'd1, 0, 32'h01);
    acc(1, 3'd2, 0, 32'h24);
    ack_base = ack_cnt; ack_lim = 2;
    begin
      logic [31:0] e;
      e = {16'hFFFF, 8'(ack_cnt + 1) + 8'h30, 8'(ack_cnt) + 8'h30};
      acc(0, 3'd4, 2, 0);
      chk("R9 partial read", rd, e); chk("R9 partial latency", lat, 4 + 3);
    end
    status = 8'h41;
    acc(0, 3'd1, 0, 0); chk("R10 pins pass", rd, 32'h41);
    ack_lim = 1000000;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule